// File: doc/BRIEF.md
# Parallel ADC acquisition controller

This block is the host-side sequencer for a 16-bit successive-approximation converter that has a parallel, tri-stated result bus. It owns the converter's three control lines: an active-low chip select, a read/convert line, and a byte-select line. It watches the converter's busy line and samples the data pins. Each finished conversion is handed on as a signed 16-bit word over a valid/ready stream. The control lines use these polarities: read/convert low is a convert command, read/convert high opens the bus, and busy low means a conversion is in progress.

Conversions run back to back at a fixed rate that a parameter sets. Each conversion goes through the same steps. A short convert pulse starts it. The block then waits for busy to rise. It opens the bus and waits out the access time before sampling the data pins. It then releases the bus.

In the 8-bit variant, chosen by the bus-width parameter, the word is read as two bytes from the same pins. The bytes are taken in order with byte-select toggled between them. If busy never returns, the block reports the fault, replays its start-up reset and carries on. Every delay is given in picoseconds and rounded up to whole clock cycles.

Top module: `adc_acq_ctrl`

## Requirements
- R1: While rst_n is low, adc_cs_n=1, adc_rc=1, adc_byte_sel=0 and res_valid=0. After release, adc_rc and adc_cs_n go low together for exactly ceil(40 ns / Tclk) cycles (10 at 4 ns). They then stay high for exactly ceil(4 us / Tclk) cycles (1000) before the first convert pulse.
- R2: Every convert pulse holds adc_rc and adc_cs_n low together for exactly ceil(40 ns / Tclk) cycles, then raises both.
- R3: Successive convert pulses start exactly ceil(PERIOD_PS / CLK_PS) cycles apart (1000 by default). This spacing is never below ceil(4 us / Tclk).
- R4: The bus is never enabled (adc_cs_n=0 with adc_rc=1) while the synchronised busy is low. A read starts only after busy has risen following a convert pulse.
- R5: Word mode (BUS_W=16): after busy rises, the bus is enabled and all 16 pins are sampled ceil(83 ns / Tclk) cycles (21) later. adc_bus[15] becomes res_data[15].
- R6: Byte mode (BUS_W=8): the high byte is read with adc_byte_sel=0, 21 cycles after the bus is enabled. adc_byte_sel then goes to 1, and the low byte is read from the same pins ceil(30 ns / Tclk) cycles (8) later. res_data = {first byte, second byte}. adc_byte_sel is 0 again once the bus is released.
- R7: res_valid stays high with res_data stable until a clock edge sees res_ready high. res_valid is low in the following cycle.
- R8: A new result that arrives while the previous one is still pending replaces it, and res_overrun is high for exactly one cycle.
- R9: If no busy rising edge is seen within ceil(TMO_PS / CLK_PS) cycles (750 by default) after a convert pulse ends, conv_timeout pulses for one cycle. In that same cycle adc_rc and adc_cs_n go low for the reset pulse. The R1 sequence then repeats and normal conversions resume.
- R10: Two's complement codes pass through unaltered: 0x7FFF (positive full scale), 0x8000 (negative full scale, res_data[15]=1), 0x0000 and 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rc | output | 1 | Read/convert: low commands a conversion, high opens the bus |
| adc_byte_sel | output | 1 | Byte select: 0 gives the high byte, 1 gives the low byte (byte mode) |
| adc_busy | input | 1 | Converter busy, low while converting (asynchronous) |
| adc_bus | input | BUS_W | Converter data pins |
| res_data | output | 16 | Signed conversion result |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_overrun | output | 1 | One-cycle pulse: an unread result was replaced |
| conv_timeout | output | 1 | One-cycle pulse: busy did not return in time |

## Verification
A converter model in the bench returns junk on the pins until the access time has elapsed since the bus was enabled, and again after each byte-select change. A controller that sampled one cycle early would therefore deliver a wrong word rather than a correct one by luck. The bench measures the pulse widths and the spacing between convert commands in cycles, so an off-by-one counter shows up directly. It stalls the consumer across two results to expose a block that drops the newer word or never flags the loss. It also silences the model's busy line to show whether the controller hangs instead of timing out and running the reset sequence again.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

   typedef enum logic [2:0] {
      ST_INIT,
      ST_RST_LO,
      ST_RST_HI,
      ST_CONV,
      ST_WAIT,
      ST_RD_HI,
      ST_RD_LO,
      ST_GAP
   } acq_st_e;

   // Minimum delay in picoseconds, rounded up to whole clock cycles.
   function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
      return (t_ps + clk_ps - 1) / clk_ps;
   endfunction

   // Pin levels per state: {cs_n, rc, byte_sel}.
   function automatic logic [2:0] pins_of(input acq_st_e s);
      logic [2:0] p;
      unique case (s)
         ST_RST_LO, ST_CONV: p = 3'b000;
         ST_RD_HI:           p = 3'b010;
         ST_RD_LO:           p = 3'b011;
         default:            p = 3'b110;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out,
   output logic rise
);

   if (STAGES < 2) begin : g_chk_stages
      $error("adc_busy_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         last_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign sync_out = chain_q[STAGES-1];
   assign rise     = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/adc_res_out.sv
module adc_res_out #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] word,
   input  logic         ready,
   output logic         valid,
   output logic [W-1:0] data,
   output logic         overrun
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         data    <= '0;
         overrun <= 1'b0;
      end else begin
         overrun <= load & valid & ~ready;
         if (load) begin
            data  <= word;
            valid <= 1'b1;
         end else if (ready) begin
            valid <= 1'b0;
         end
      end
   end

   // R7: a pending result is held until taken
   a_r7_hold_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready && !load) |=> (valid && $stable(data)));

   // R8: the loss flag only accompanies a pending replacement
   a_r8_flag_with_valid : assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> valid);

endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
   import adc_acq_pkg::*;
#(
   parameter int unsigned BUS_W       = 16,
   parameter int unsigned CLK_PS      = 4000,
   parameter int unsigned PERIOD_PS   = 4_000_000,
   parameter int unsigned TMO_PS      = 3_000_000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             adc_cs_n,
   output logic             adc_rc,
   output logic             adc_byte_sel,
   input  logic             adc_busy,
   input  logic [BUS_W-1:0] adc_bus,
   output logic [15:0]      res_data,
   output logic             res_valid,
   input  logic             res_ready,
   output logic             res_overrun,
   output logic             conv_timeout
);

   localparam int unsigned PULSE_CYC  = ps_to_cyc(40_000, CLK_PS);
   localparam int unsigned ACC_CYC    = ps_to_cyc(83_000, CLK_PS);
   localparam int unsigned BYTE_CYC   = ps_to_cyc(30_000, CLK_PS);
   localparam int unsigned CYCLE_CYC  = ps_to_cyc(4_000_000, CLK_PS);
   localparam int unsigned PERIOD_CYC = ps_to_cyc(PERIOD_PS, CLK_PS);
   localparam int unsigned TMO_CYC    = ps_to_cyc(TMO_PS, CLK_PS);
   localparam bit          BYTE_MODE  = (BUS_W == 8);
   localparam int unsigned CNT_TOP    = (CYCLE_CYC > TMO_CYC) ? CYCLE_CYC : TMO_CYC;
   localparam int unsigned CNT_W      = $clog2(CNT_TOP + 1);
   localparam int unsigned PER_W      = $clog2(PERIOD_CYC + 1);

   // Elaboration-time parameter checks
   if (BUS_W != 8 && BUS_W != 16) begin : g_chk_bus
      $error("adc_acq_ctrl: BUS_W must be 8 or 16");
   end
   if (PERIOD_CYC < CYCLE_CYC) begin : g_chk_period
      $error("adc_acq_ctrl: PERIOD_PS below the 4 us minimum cycle");
   end
   if (PULSE_CYC < 2 || PULSE_CYC * CLK_PS >= 1_000_000) begin : g_chk_pulse
      $error("adc_acq_ctrl: convert pulse must be 2 cycles or more and well under the busy-low time");
   end
   if (TMO_CYC < 2) begin : g_chk_tmo
      $error("adc_acq_ctrl: TMO_PS too small");
   end

   acq_st_e          st_q, st_d;
   logic [CNT_W-1:0] cnt_q;
   logic [PER_W-1:0] per_q;
   logic             busy_s, busy_rise;
   logic             cap_hi, cap_lo, tmo;
   logic             ld_res;
   logic [15:0]      res_word;

   adc_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (adc_busy),
      .sync_out (busy_s),
      .rise     (busy_rise)
   );

   always_comb begin
      st_d   = st_q;
      cap_hi = 1'b0;
      cap_lo = 1'b0;
      tmo    = 1'b0;
      unique case (st_q)
         ST_INIT:   st_d = ST_RST_LO;
         ST_RST_LO: if (cnt_q == CNT_W'(PULSE_CYC - 1)) st_d = ST_RST_HI;
         ST_RST_HI: if (cnt_q == CNT_W'(CYCLE_CYC - 1)) st_d = ST_CONV;
         ST_CONV:   if (cnt_q == CNT_W'(PULSE_CYC - 1)) st_d = ST_WAIT;
         ST_WAIT: begin
            if (busy_rise) begin
               st_d = ST_RD_HI;
            end else if (cnt_q == CNT_W'(TMO_CYC - 1)) begin
               tmo  = 1'b1;
               st_d = ST_RST_LO;
            end
         end
         ST_RD_HI: begin
            if (cnt_q == CNT_W'(ACC_CYC - 1)) begin
               cap_hi = 1'b1;
               st_d   = BYTE_MODE ? ST_RD_LO : ST_GAP;
            end
         end
         ST_RD_LO: begin
            if (cnt_q == CNT_W'(BYTE_CYC - 1)) begin
               cap_lo = 1'b1;
               st_d   = ST_GAP;
            end
         end
         ST_GAP:   if (per_q >= PER_W'(PERIOD_CYC - 1)) st_d = ST_CONV;
         default:  st_d = ST_INIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q                              <= ST_INIT;
         cnt_q                             <= '0;
         per_q                             <= '0;
         {adc_cs_n, adc_rc, adc_byte_sel}  <= 3'b110;
         conv_timeout                      <= 1'b0;
      end else begin
         st_q                              <= st_d;
         {adc_cs_n, adc_rc, adc_byte_sel}  <= pins_of(st_d);
         conv_timeout                      <= tmo;
         if (st_d != st_q)
            cnt_q <= '0;
         else if (cnt_q != CNT_W'(CNT_TOP))
            cnt_q <= cnt_q + 1'b1;
         if (st_d == ST_CONV && st_q != ST_CONV)
            per_q <= '0;
         else if (per_q != PER_W'(PERIOD_CYC))
            per_q <= per_q + 1'b1;
      end
   end

   // Result assembly: whole word, or two bytes taken from the same pins
   if (BYTE_MODE) begin : g_byte
      logic [7:0] hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      hi_q <= '0;
         else if (cap_hi) hi_q <= adc_bus[7:0];
      end
      assign res_word = {hi_q, adc_bus[7:0]};
   end else begin : g_word
      assign res_word = adc_bus[15:0];
   end

   assign ld_res = BYTE_MODE ? cap_lo : cap_hi;

   adc_res_out #(.W(16)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ld_res),
      .word    (res_word),
      .ready   (res_ready),
      .valid   (res_valid),
      .data    (res_data),
      .overrun (res_overrun)
   );

   // R4: bus only opened while the converter reports idle
   a_r4_no_read_busy : assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_cs_n && adc_rc) |-> busy_s);

   // R2: a convert pulse is never a single cycle
   a_r2_pulse_min : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_rc) |=> !adc_rc);

   // R6: byte select only moves during an open read
   a_r6_byte_in_read : assert property (@(posedge clk) disable iff (!rst_n)
      adc_byte_sel |-> (!adc_cs_n && adc_rc));

   // R9: timeout coincides with the start of the reset pulse
   a_r9_tmo_reset : assert property (@(posedge clk) disable iff (!rst_n)
      conv_timeout |-> (!adc_rc && !adc_cs_n));

endmodule

// File: tb/adc_acq_ctrl_tb.sv
module adc_conv_model #(
   parameter int BUS_W    = 16,
   parameter int CONV_CYC = 400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             rc,
   input  logic             byte_sel,
   input  logic             dead,
   input  logic [15:0]      next_code,
   output logic             busy,
   output logic [BUS_W-1:0] bus,
   output int               n_start,
   output int               n_viol
);
   logic        cn_q, bs_q, ok;
   logic [15:0] held, result, full;
   int          ctr, en_cnt, bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cn_q <= 1'b1; busy <= 1'b1; held <= '0; result <= '0; ctr <= 0;
         en_cnt <= 0; bcnt <= 100; bs_q <= 1'b0; n_start <= 0; n_viol <= 0;
      end else begin
         cn_q <= cs_n | rc;
         if (cn_q && !(cs_n | rc) && !dead) begin
            if (busy) begin
               busy <= 1'b0; held <= next_code; ctr <= CONV_CYC; n_start <= n_start + 1;
            end else begin
               busy <= 1'b1; ctr <= 0;
            end
         end else if (!busy) begin
            if (ctr <= 1) begin busy <= 1'b1; result <= held; end
            ctr <= ctr - 1;
         end
         en_cnt <= (!cs_n && rc) ? ((en_cnt < 1000) ? en_cnt + 1 : en_cnt) : 0;
         if (byte_sel != bs_q) bcnt <= 1;
         else if (bcnt < 1000) bcnt <= bcnt + 1;
         bs_q <= byte_sel;
         if (!cs_n && rc && !busy) n_viol <= n_viol + 1;
      end
   end

   assign ok = (en_cnt >= 20) && (bcnt >= 7);

   always_comb begin
      if (BUS_W == 16) full = ok ? result : 16'hA5C3;
      else full = {8'h00, ok ? (byte_sel ? result[7:0] : result[15:8]) : 8'h5A};
   end
   assign bus = full[BUS_W-1:0];
endmodule

module adc_acq_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n;
   always #2 clk = ~clk;

   logic        cs_n_a, rc_a, bs_a, busy_a, valid_a, rdy_a, ovr_a, tmo_a, dead_a;
   logic [15:0] bus_a, data_a, code_a;
   logic        cs_n_b, rc_b, bs_b, busy_b, valid_b, rdy_b, ovr_b, tmo_b;
   logic [7:0]  bus_b;
   logic [15:0] data_b, code_b;
   int          ns_a, ns_b, viol_a, viol_b;
   int          n_cmp = 0, n_bad = 0, cyc = 0;
   int          lo_run = 0, lo_len = 0, since_fall = 0, gap = 0;
   logic        rc_prev = 1'b1;

   adc_acq_ctrl #(.BUS_W(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .adc_cs_n(cs_n_a), .adc_rc(rc_a), .adc_byte_sel(bs_a),
      .adc_busy(busy_a), .adc_bus(bus_a), .res_data(data_a), .res_valid(valid_a),
      .res_ready(rdy_a), .res_overrun(ovr_a), .conv_timeout(tmo_a));

   adc_conv_model #(.BUS_W(16)) u_mdl_a (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n_a), .rc(rc_a), .byte_sel(bs_a), .dead(dead_a),
      .next_code(code_a), .busy(busy_a), .bus(bus_a), .n_start(ns_a), .n_viol(viol_a));

   adc_acq_ctrl #(.BUS_W(8)) u_dut_b (
      .clk(clk), .rst_n(rst_n), .adc_cs_n(cs_n_b), .adc_rc(rc_b), .adc_byte_sel(bs_b),
      .adc_busy(busy_b), .adc_bus(bus_b), .res_data(data_b), .res_valid(valid_b),
      .res_ready(rdy_b), .res_overrun(ovr_b), .conv_timeout(tmo_b));

   adc_conv_model #(.BUS_W(8)) u_mdl_b (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n_b), .rc(rc_b), .byte_sel(bs_b), .dead(1'b0),
      .next_code(code_b), .busy(busy_b), .bus(bus_b), .n_start(ns_b), .n_viol(viol_b));

   // Pulse width and spacing monitor on the word-mode read/convert line
   always @(negedge clk) begin
      if (!rc_a && rc_prev) begin gap = since_fall + 1; since_fall = 0; lo_run = 1; end
      else begin
         since_fall = since_fall + 1;
         if (!rc_a) lo_run = lo_run + 1;
         if (rc_a && !rc_prev) lo_len = lo_run;
      end
      rc_prev = rc_a;
   end

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc == 190000) begin
         n_cmp = n_cmp + 1; n_bad = n_bad + 1;
         $display("FAIL watchdog expired actual=%0d expected=<190000 cycles", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp = n_cmp + 1;
      if (act !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic sample_a(input logic [15:0] code, output logic [15:0] got);
      int n; int lim;
      code_a = code; n = ns_a;
      lim = 0; while (ns_a == n && lim < 3000) begin @(negedge clk); lim++; end
      lim = 0; while (!valid_a && lim < 3000) begin @(negedge clk); lim++; end
      got = valid_a ? data_a : ~code;
      @(negedge clk);
   endtask

   task automatic sample_b(input logic [15:0] code, output logic [15:0] got);
      int n; int lim;
      code_b = code; n = ns_b;
      lim = 0; while (ns_b == n && lim < 3000) begin @(negedge clk); lim++; end
      lim = 0; while (!valid_b && lim < 3000) begin @(negedge clk); lim++; end
      got = valid_b ? data_b : ~code;
      @(negedge clk);
   endtask

   task automatic t_reset_startup();
      int lo; int hi;
      repeat (5) @(negedge clk);
      chk("R1", "cs_n in reset", cs_n_a, 1);
      chk("R1", "rc in reset", rc_a, 1);
      chk("R1", "byte_sel in reset", bs_b, 0);
      chk("R1", "valid in reset", valid_a, 0);
      rst_n = 1'b1;
      @(negedge clk);
      lo = 0; while (!rc_a && lo < 5000) begin lo++; @(negedge clk); end
      chk("R1", "reset pulse length", lo, 10);
      hi = 0; while (rc_a && hi < 5000) begin hi++; @(negedge clk); end
      chk("R1", "quiet time before first convert", hi, 1000);
   endtask

   task automatic t_codes();
      logic [15:0] got;
      sample_a(16'h1234, got); chk("R5", "word 1234", got, 16'h1234);
      sample_a(16'h7FFF, got); chk("R10", "plus full scale", got, 16'h7FFF);
      sample_a(16'h8000, got); chk("R10", "minus full scale", got, 16'h8000);
      chk("R10", "sign bit of minus full scale", got[15], 1);
      sample_a(16'h0000, got); chk("R10", "midscale", got, 16'h0000);
      sample_a(16'hFFFF, got); chk("R10", "one below midscale", got, 16'hFFFF);
   endtask

   task automatic t_timing();
      logic [15:0] got;
      sample_a(16'h0F0F, got);
      chk("R2", "convert pulse width", lo_len, 10);
      chk("R3", "convert spacing", gap, 1000);
      chk("R5", "word 0F0F", got, 16'h0F0F);
   endtask

   task automatic t_byte();
      logic [15:0] got;
      sample_b(16'hBEEF, got); chk("R6", "byte mode BEEF", got, 16'hBEEF);
      sample_b(16'h8001, got); chk("R6", "byte mode 8001", got, 16'h8001);
      sample_b(16'h00FF, got); chk("R6", "byte mode 00FF", got, 16'h00FF);
      chk("R6", "byte_sel low after read", bs_b, 0);
   endtask

   task automatic t_hold_overrun();
      logic [15:0] got;
      bit stable; int lim; int n;
      sample_a(16'h1111, got);
      rdy_a = 1'b0; code_a = 16'h5A5A; n = ns_a;
      lim = 0; while (ns_a == n && lim < 3000) begin @(negedge clk); lim++; end
      lim = 0; while (!valid_a && lim < 3000) begin @(negedge clk); lim++; end
      chk("R7", "pending data", data_a, 16'h5A5A);
      stable = 1'b1;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (!valid_a || data_a !== 16'h5A5A) stable = 1'b0;
      end
      chk("R7", "held while not ready", stable, 1);
      code_a = 16'hC3C3;
      lim = 0; while (!ovr_a && lim < 3000) begin @(negedge clk); lim++; end
      chk("R8", "overrun seen", ovr_a, 1);
      chk("R8", "newer word kept", data_a, 16'hC3C3);
      @(negedge clk);
      chk("R8", "overrun one cycle", ovr_a, 0);
      rdy_a = 1'b1;
      @(negedge clk);
      chk("R7", "valid drops after accept", valid_a, 0);
   endtask

   task automatic t_timeout();
      logic [15:0] got;
      int lim;
      sample_a(16'h2222, got);
      dead_a = 1'b1;
      lim = 0; while (!tmo_a && lim < 3000) begin @(negedge clk); lim++; end
      chk("R9", "timeout flagged", tmo_a, 1);
      chk("R9", "reset pulse with timeout", {rc_a, cs_n_a}, 2'b00);
      dead_a = 1'b0;
      @(negedge clk);
      chk("R9", "timeout one cycle", tmo_a, 0);
      repeat (20) @(negedge clk);
      sample_a(16'h2468, got);
      chk("R9", "recovered sample", got, 16'h2468);
   endtask

   initial begin
      rst_n = 1'b0; rdy_a = 1'b1; rdy_b = 1'b1; dead_a = 1'b0;
      code_a = '0; code_b = '0;
      t_reset_startup();
      t_codes();
      t_timing();
      t_byte();
      t_hold_overrun();
      t_timeout();
      chk("R4", "reads while busy, word mode", viol_a, 0);
      chk("R4", "reads while busy, byte mode", viol_b, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule